// File: doc/BRIEF.md
# Smart Card Clock Pin Controller

This block owns the clock pin of a smart card serial port. It either hands the pin over to the general-purpose port logic, or it drives the pin with a card clock. The card clock is derived from the system clock by a prescaler and a programmable rate divider. In clock mode, one run bit starts and stops the card clock while the system is live. A second bit picks the level at which the pin rests while the clock is stopped.

Starting and stopping never disturb the waveform. A stop request lets the half period in progress run to its end before the pin settles at the rest level. A start request begins with a full phase opposite to the rest level. A ready flag tells software that at least one whole card clock period has been emitted, so that the transmit and receive paths may be switched on.

Top module: `sc_clk_pin_ctrl`

## Requirements
- R1: Whenever `card_mode_en` is 0 or `clk_sync_sel` is 0, `pin_is_clk` is 0 and `pin_out` equals `port_level` in the same cycle.
- R2: With `card_mode_en`=1, `clk_sync_sel`=1, `clk_run`=0 and `park_high_sel`=0, `pin_out` settles at 0 within one half period and stays there.
- R3: With `card_mode_en`=1, `clk_sync_sel`=1, `clk_run`=0 and `park_high_sel`=1, `pin_out` settles at 1 within one half period and stays there.
- R4: With `clk_run`=1 in clock mode, `pin_out` is a square wave whose high and low phases each last exactly H system cycles, whatever the value of `park_high_sel`.
- R5: When `clk_run` falls, the phase in progress still lasts its full H cycles. The pin then holds the rest level, and no phase is ever shorter than H.
- R6: When `clk_run` rises while stopped, the pin changes at the end of the current half period. The first phase has the level opposite to the rest level and lasts H cycles.
- R7: H = (`rate_div`+1) × 4^`presc_sel`, so `presc_sel` values 0, 1, 2 and 3 scale by 1, 4, 16 and 64.
- R8: `clk_ready` is 0 on the first and second pin transitions after a start, and it becomes 1 together with the third. It falls one cycle after the clock stops or one cycle after `pin_is_clk` falls.
- R9: A change of `presc_sel` or `rate_div` restarts the divider from zero on the next edge. The phase in progress then lasts 1+H_new more cycles, counted from the sample at which the change was applied.
- R10: During and right after reset, `pin_out` is 0 in clock mode, the clock is stopped and `clk_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_mode_en | input | 1 | Smart card mode enable |
| clk_sync_sel | input | 1 | 1 = clock mode, 0 = pin left to port logic |
| park_high_sel | input | 1 | Rest level while stopped (1 = high) |
| clk_run | input | 1 | 1 = emit card clock, 0 = rest |
| port_level | input | 1 | General-purpose port level for the pin |
| presc_sel | input | 2 | Prescaler select |
| rate_div | input | 8 | Rate divider value |
| pin_out | output | 1 | Value driven on the clock pin |
| pin_is_clk | output | 1 | 1 = pin driven by clock logic, 0 = by port logic |
| clk_ready | output | 1 | At least one full card clock period has been emitted |

## Verification
On every cycle, the assertions check the following: the port pass-through, that the generator level moves only on a divider tick, that no pin phase is shorter than the current half period, the rest level after a stop tick, the inversion on restart, the ready flag rising only on a tick, and the divider clearing after a configuration change. Other behaviour needs the bench's scenarios. These are the exact phase length for each prescaler and divider pair, the remaining length of a phase cut by a stop or by a rate change, the level of the first phase after a restart, and the transition on which the ready flag rises.

// File: rtl/sc_clk_pkg.sv
// Package: shared types for the smart card clock pin controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sc_clk_pkg;

    // Generator state: resting at a fixed level, or emitting clock phases.
    typedef enum logic {
        GEN_PARKED  = 1'b0,
        GEN_RUNNING = 1'b1
    } gen_state_e;

endpackage

// File: rtl/sc_clk_divider.sv
// Module: half-period divider. Emits a one-cycle phase_tick at the end of
// every half period of H = (rate_div+1) << (PSHIFT_STEP*presc_sel) cycles.
// Assumes: presc_sel and rate_div are synchronous to clk. Any change of
// either clears the counter and suppresses the tick in that cycle.
module sc_clk_divider #(
    parameter int DIV_W       = 8,
    parameter int PSEL_W      = 2,
    parameter int PSHIFT_STEP = 2,
    localparam int PSEL_N     = 1 << PSEL_W,
    localparam int MAX_SHIFT  = PSHIFT_STEP * (PSEL_N - 1),
    localparam int CNT_W      = DIV_W + 1 + MAX_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic [DIV_W-1:0]  rate_div,
    output logic              phase_tick,
    output logic [CNT_W-1:0]  div_cnt
);

    logic [CNT_W-1:0]  base_len;
    logic [CNT_W-1:0]  scaled_len [PSEL_N];
    logic [CNT_W-1:0]  half_len;
    logic [PSEL_W-1:0] presc_q;
    logic [DIV_W-1:0]  rate_q;
    logic              cfg_change;

    // Unscaled half-period length from the divider register.
    assign base_len = CNT_W'(rate_div) + CNT_W'(1);

    // One scaled length per prescaler setting.
    for (genvar g = 0; g < PSEL_N; g++) begin : g_scale
        assign scaled_len[g] = base_len << (g * PSHIFT_STEP);
    end

    // Pick the active scaled length.
    assign half_len = scaled_len[presc_sel];

    // Detect a write of either configuration value.
    assign cfg_change = (presc_sel != presc_q) || (rate_div != rate_q);

    // Tick when the counter reaches the last cycle of the half period.
    assign phase_tick = !cfg_change && (div_cnt == half_len - CNT_W'(1));

    // Remember the previous configuration for change detection.
    always_ff @(posedge clk) begin
        presc_q <= presc_sel;
        rate_q  <= rate_div;
    end

    // Half-period counter, cleared on reset, on a tick and on a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (cfg_change || phase_tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sc_clk_phase_gen.sv
// Module: phase generator. Holds the card clock level and its run/park state.
// The level moves only on phase_tick, so every phase lasts a whole half
// period. A stop request lets the current phase finish and then rests at
// park_high. A start request begins with the phase opposite to the rest level.
// Assumes: phase_tick is a single-cycle pulse from the divider.
module sc_clk_phase_gen
    import sc_clk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_tick,
    input  logic run_req,
    input  logic park_high,
    output logic level,
    output logic running
);

    gen_state_e state;

    assign running = (state == GEN_RUNNING);

    // Advance level and state at each half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GEN_PARKED;
            level <= 1'b0;
        end else if (phase_tick) begin
            unique case (state)
                GEN_RUNNING: begin
                    if (run_req) begin
                        level <= ~level;
                    end else begin
                        level <= park_high;
                        state <= GEN_PARKED;
                    end
                end
                GEN_PARKED: begin
                    if (run_req) begin
                        level <= ~level;
                        state <= GEN_RUNNING;
                    end else begin
                        level <= park_high;
                    end
                end
                default: state <= GEN_PARKED;
            endcase
        end
    end

endmodule

// File: rtl/sc_clk_ready_mon.sv
// Module: ready monitor. Raises ready once READY_PHASES full phases have been
// emitted while the generator runs and the pin is in clock mode. Clears one
// cycle after either condition drops.
// Assumes: running and phase_tick come from the phase generator and divider.
module sc_clk_ready_mon #(
    parameter int READY_PHASES = 2,
    localparam int RC_W        = $clog2(READY_PHASES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_tick,
    input  logic running,
    input  logic drive_en,
    output logic ready
);

    logic [RC_W-1:0] phase_cnt;

    // Count completed phases, saturating at READY_PHASES.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            ready     <= 1'b0;
        end else if (!drive_en || !running) begin
            phase_cnt <= '0;
            ready     <= 1'b0;
        end else if (phase_tick && (phase_cnt != RC_W'(READY_PHASES))) begin
            phase_cnt <= phase_cnt + RC_W'(1);
            if (phase_cnt == RC_W'(READY_PHASES - 1)) begin
                ready <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sc_clk_pin_ctrl.sv
// Module: smart card clock pin controller (top). Chooses between port drive
// and card clock drive for the pin. Builds the clock from the divider and
// the phase generator, and flags when one full clock period has gone out.
// Assumes: all control inputs are synchronous to clk.
module sc_clk_pin_ctrl #(
    parameter int DIV_W        = 8,
    parameter int PSEL_W       = 2,
    parameter int PSHIFT_STEP  = 2,
    parameter int READY_PHASES = 2,
    localparam int CNT_W       = DIV_W + 1 + PSHIFT_STEP * ((1 << PSEL_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_mode_en,
    input  logic              clk_sync_sel,
    input  logic              park_high_sel,
    input  logic              clk_run,
    input  logic              port_level,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic [DIV_W-1:0]  rate_div,
    output logic              pin_out,
    output logic              pin_is_clk,
    output logic              clk_ready
);

    logic             phase_tick;
    logic [CNT_W-1:0] div_cnt;
    logic             gen_level;
    logic             gen_running;

    // Half-period timing.
    sc_clk_divider #(
        .DIV_W      (DIV_W),
        .PSEL_W     (PSEL_W),
        .PSHIFT_STEP(PSHIFT_STEP)
    ) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_sel (presc_sel),
        .rate_div  (rate_div),
        .phase_tick(phase_tick),
        .div_cnt   (div_cnt)
    );

    // Clock level and run/park control.
    sc_clk_phase_gen gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_tick(phase_tick),
        .run_req   (clk_run),
        .park_high (park_high_sel),
        .level     (gen_level),
        .running   (gen_running)
    );

    // One-period-emitted flag.
    sc_clk_ready_mon #(
        .READY_PHASES(READY_PHASES)
    ) rdy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_tick(phase_tick),
        .running   (gen_running),
        .drive_en  (pin_is_clk),
        .ready     (clk_ready)
    );

    // Pin ownership: clock logic only in card mode with clock select set.
    assign pin_is_clk = card_mode_en && clk_sync_sel;

    // Pin value mux.
    assign pin_out = pin_is_clk ? gen_level : port_level;

endmodule

// File: rtl/sc_clk_pin_ctrl_chk.sv
// Module: assertion checker for sc_clk_pin_ctrl, bound to every instance.
// Tracks how long the generator level has held and checks phase lengths,
// park/restart behaviour, the ready flag and the divider clear.
// Assumes: same parameters as the bound top.
module sc_clk_pin_ctrl_chk #(
    parameter int DIV_W        = 8,
    parameter int PSEL_W       = 2,
    parameter int PSHIFT_STEP  = 2,
    localparam int CNT_W       = DIV_W + 1 + PSHIFT_STEP * ((1 << PSEL_W) - 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              card_mode_en,
    input logic              clk_sync_sel,
    input logic              park_high_sel,
    input logic              clk_run,
    input logic              port_level,
    input logic [PSEL_W-1:0] presc_sel,
    input logic [DIV_W-1:0]  rate_div,
    input logic              pin_out,
    input logic              pin_is_clk,
    input logic              clk_ready,
    input logic              phase_tick,
    input logic [CNT_W-1:0]  div_cnt,
    input logic              gen_level,
    input logic              gen_running
);

    logic [CNT_W-1:0] hlen;
    logic [CNT_W:0]   run_len;
    logic             lvl_q;
    logic             seen;

    // Expected half period from the current configuration.
    always_comb begin
        hlen = (CNT_W'(rate_div) + CNT_W'(1)) << (int'(presc_sel) * PSHIFT_STEP);
    end

    // Track the length of the level currently held by the generator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            run_len <= '0;
            seen    <= 1'b0;
        end else begin
            lvl_q <= gen_level;
            if (gen_level != lvl_q) begin
                run_len <= (CNT_W+1)'(1);
                seen    <= 1'b1;
            end else if (run_len != '1) begin
                run_len <= run_len + (CNT_W+1)'(1);
            end
        end
    end

    // R1: port logic owns the pin outside clock mode.
    assert_port_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_mode_en && clk_sync_sel) |-> (pin_out == port_level) && !pin_is_clk);

    // R2, R3, R5: a tick without run request leaves the generator parked at the rest level.
    assert_park_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick && !clk_run) |=> !gen_running && (gen_level == $past(park_high_sel)));

    // R5: the level moves only at a half-period boundary.
    assert_level_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_tick |=> $stable(gen_level));

    // R5: no complete phase is shorter than the half period.
    assert_min_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (gen_level != lvl_q)) |-> (run_len >= (CNT_W+1)'($past(hlen))));

    // R6: restart from rest inverts the level and enters the running state.
    assert_restart_invert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_running && phase_tick && clk_run) |=> gen_running && (gen_level != $past(gen_level)));

    // R8: ready rises only at a half-period boundary.
    assert_ready_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ready) |-> $past(phase_tick));

    // R8: ready drops after the pin leaves clock mode.
    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_clk |=> !clk_ready);

    // R9: a configuration change clears the divider on the next edge.
    assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate_div != $past(rate_div)) || (presc_sel != $past(presc_sel))) |=> (div_cnt == '0));

endmodule

bind sc_clk_pin_ctrl sc_clk_pin_ctrl_chk #(
    .DIV_W      (DIV_W),
    .PSEL_W     (PSEL_W),
    .PSHIFT_STEP(PSHIFT_STEP)
) chk_i (.*);

// File: tb/sc_clk_pin_ctrl_tb_top.sv
// Bench for sc_clk_pin_ctrl: directed corner cases plus seeded random
// configurations. Phase lengths are measured at the pin against bench-computed values.
module sc_clk_pin_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       card_mode_en, clk_sync_sel, park_high_sel, clk_run, port_level;
    logic [1:0] presc_sel;
    logic [7:0] rate_div;
    logic       pin_out, pin_is_clk, clk_ready;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sc_clk_pin_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .card_mode_en(card_mode_en),
        .clk_sync_sel(clk_sync_sel), .park_high_sel(park_high_sel),
        .clk_run(clk_run), .port_level(port_level), .presc_sel(presc_sel),
        .rate_div(rate_div), .pin_out(pin_out), .pin_is_clk(pin_is_clk),
        .clk_ready(clk_ready)
    );

    function automatic int exp_half(int p, int r);
        return (r + 1) << (2 * p);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Cycles from the current sample until pin_out next changes.
    task automatic wait_change(output int len);
        logic lvl = pin_out;
        len = 0;
        forever begin
            @(negedge clk);
            len++;
            if (pin_out != lvl) break;
            if (len > 5000) begin
                check(0, "TIMEOUT", "no pin transition", len, 0);
                break;
            end
        end
    endtask

    task automatic hold_check(input string req, input int n, input logic lvl);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_out != lvl) bad++;
        end
        check(bad == 0, req, "pin held at level (bad samples)", bad, 0);
    endtask

    task automatic set_cfg(input int p, input int r);
        presc_sel = 2'(p);
        rate_div  = 8'(r);
    endtask

    // Start the clock and check several full phases.
    task automatic run_check(input int p, input int r, input string req);
        int len;
        int h = exp_half(p, r);
        set_cfg(p, r);
        clk_run = 1'b1;
        park_high_sel = 1'($urandom_range(0, 1));
        wait_change(len);
        for (int i = 0; i < 3; i++) begin
            wait_change(len);
            check(len == h, req, "running phase length", len, h);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len, h, k;
        logic lvl;
        void'($urandom(32'h5C0C1));
        rst_n = 1'b0; card_mode_en = 1'b1; clk_sync_sel = 1'b1;
        park_high_sel = 1'b0; clk_run = 1'b0; port_level = 1'b0;
        set_cfg(0, 3);
        repeat (3) @(negedge clk);
        check(pin_out == 1'b0 && clk_ready == 1'b0, "R10", "pin/ready in reset",
              {pin_out, clk_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pin_out == 1'b0 && clk_ready == 1'b0 && pin_is_clk == 1'b1, "R10",
              "pin/ready/owner after reset", {pin_out, clk_ready, pin_is_clk}, 1);

        // R1: port pass-through, both ways of leaving clock mode.
        for (int i = 0; i < 8; i++) begin
            card_mode_en = 1'($urandom_range(0, 1));
            clk_sync_sel = card_mode_en ? 1'b0 : 1'($urandom_range(0, 1));
            port_level   = 1'($urandom_range(0, 1));
            clk_run      = 1'($urandom_range(0, 1));
            @(negedge clk);
            check(pin_out == port_level && !pin_is_clk, "R1", "port pass-through",
                  {pin_is_clk, pin_out}, {1'b0, port_level});
        end
        card_mode_en = 1'b1; clk_sync_sel = 1'b1; clk_run = 1'b0;

        // R2: rest low.
        park_high_sel = 1'b0;
        repeat (10) @(negedge clk);
        hold_check("R2", 12, 1'b0);
        // R3: rest high.
        park_high_sel = 1'b1;
        repeat (10) @(negedge clk);
        hold_check("R3", 12, 1'b1);

        // R4, R7: directed extremes then random configurations.
        run_check(0, 0, "R4");
        run_check(3, 0, "R7");
        run_check(2, 3, "R7");
        for (int i = 0; i < 8; i++) begin
            int p = $urandom_range(0, 2);
            int r = (p == 2) ? $urandom_range(0, 3) : $urandom_range(0, 15);
            run_check(p, r, "R4");
        end

        // R5 and R6/R8: stop mid-phase, rest, then restart, several times.
        for (int i = 0; i < 4; i++) begin
            int p = $urandom_range(0, 1);
            int r = $urandom_range(1, 7);
            h = exp_half(p, r);
            set_cfg(p, r);
            clk_run = 1'b1;
            wait_change(len);
            wait_change(len);
            lvl = pin_out;
            k = $urandom_range(1, h - 1);
            repeat (k) @(negedge clk);
            clk_run = 1'b0;
            park_high_sel = ~lvl;
            wait_change(len);
            check(len == h - k, "R5", "remaining length of phase cut by stop", len, h - k);
            check(pin_out == ~lvl, "R5", "rest level after stop", pin_out, ~lvl);
            hold_check("R5", 3 * h, ~lvl);
            check(clk_ready == 1'b0, "R8", "ready low while stopped", clk_ready, 0);
            // Restart.
            clk_run = 1'b1;
            wait_change(len);
            check(pin_out == lvl, "R6", "first phase opposite rest level", pin_out, lvl);
            check(clk_ready == 1'b0, "R8", "ready at first transition", clk_ready, 0);
            wait_change(len);
            check(len == h, "R6", "first phase length after restart", len, h);
            check(clk_ready == 1'b0, "R8", "ready at second transition", clk_ready, 0);
            wait_change(len);
            check(clk_ready == 1'b1, "R8", "ready at third transition", clk_ready, 1);
        end

        // R8: ready falls one cycle after leaving clock mode.
        clk_sync_sel = 1'b0;
        @(negedge clk);
        check(clk_ready == 1'b0, "R8", "ready after leaving clock mode", clk_ready, 0);
        clk_sync_sel = 1'b1;

        // R9: divider rewrite mid-phase.
        for (int i = 0; i < 3; i++) begin
            int hn;
            set_cfg(1, 2);
            h = exp_half(1, 2);
            clk_run = 1'b1;
            wait_change(len);
            wait_change(len);
            k = $urandom_range(1, h - 2);
            repeat (k) @(negedge clk);
            set_cfg(1, 5 + i);
            hn = exp_half(1, 5 + i);
            wait_change(len);
            check(len == hn + 1, "R9", "phase remainder after rate rewrite", len, hn + 1);
            wait_change(len);
            check(len == hn, "R9", "phase after rate rewrite", len, hn);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule